// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits beside a floating-point execution unit and keeps the 32-bit floating-point status word. When the unit finishes an operation it presents the five IEEE exception flags with a valid strobe. The recorder compares them with the trap-enable mask held in the status word and decides whether the operation traps. On a trap it narrows the report to the enabled flags, and to one flag by priority when several remain. It then rewrites the current-exception field, either accumulates into or clears the accrued-exception field, and marks the trap type. A registered `ok_q` output tells the surrounding control whether the exception must be signalled (0) or can be absorbed (1).

Software or a context-restore path loads the whole status word through a write port. The recorder does not compute the flags itself.

Top module: `fpx_status_rec`

## Requirements
- R1: While reset is asserted and after it is released, `status_q` is zero and `ok_q` is 1.
- R2: With `wr_en` high, `status_q` takes `wr_data` on the next clock edge. A flag event offered in the same cycle is dropped and `ok_q` keeps its value.
- R3: Flag bit positions are invalid=4, overflow=3, underflow=2, divide-by-zero=1 and inexact=0, and they are the same in every field. An event traps exactly when `flag_vec & status_q[27:23]` is non-zero. One cycle after the event, `ok_q` is 0 on a trap and 1 otherwise.
- R4: On a trap, the reported flags are the incoming flags ANDed with the enable mask. If more than one bit remains, only one is kept: invalid first, then divide-by-zero, then inexact. If none of those three is present, the masked set is kept unchanged.
- R5: On every event with non-zero flags, the current-exception field `status_q[4:0]` is replaced by the reported flags. No earlier content survives.
- R6: Without a trap, if the flags contain overflow or underflow, inexact (bit 0) is also set in the current-exception field. It is not added to the accrued field.
- R7: Without a trap, the incoming flags are ORed into the accrued field `status_q[9:5]`. On a trap, the accrued field becomes zero.
- R8: A trap sets `status_q[14]`. Without a trap, bit 14 keeps its value. All bits outside the two exception fields and bit 14 are never changed by a flag event.
- R9: A valid event with `flag_vec` zero leaves `status_q` unchanged and sets `ok_q` to 1.
- R10: In cycles with neither `wr_en` nor `flag_vld`, `status_q` and `ok_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the whole status word |
| wr_data | input | 32 | Value loaded when `wr_en` is high |
| flag_vld | input | 1 | Exception flag event strobe |
| flag_vec | input | 5 | IEEE exception flags of the finished operation |
| status_q | output | 32 | Current status word |
| ok_q | output | 1 | 1 = exception absorbed, 0 = signal it; set by the latest event |

## Verification
The in-RTL properties check on every cycle the coarse consequences of a trap, each of them a single edge away:
- `ok_q` low;
- accrued field cleared;
- trap-type bit set;
- no current-exception bit outside the enable mask.

They also check, on every cycle, the hold behaviour in idle cycles and on zero-flag events, the priority of the write port, and the extra inexact bit on non-trapped overflow or underflow. The exact narrowed value under each mask-and-flag combination, the exact accrued bits after accumulation, and the preservation of unrelated status bits are shown only by the bench's table of scenarios. That table includes the case where overflow and underflow both survive masking and are reported together.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W    = 5;
  localparam int XV_INV    = 4;
  localparam int XV_OVF    = 3;
  localparam int XV_UNF    = 2;
  localparam int XV_DZ     = 1;
  localparam int XV_NX     = 0;
  localparam int STAT_W    = 32;
  localparam int MASK_LSB  = 23;
  localparam int ACC_LSB   = 5;
  localparam int CUR_LSB   = 0;
  localparam int TTYPE_BIT = 14;

  typedef logic [FLAG_W-1:0] xflags_t;

  function automatic xflags_t one_hot_at(int pos);
    xflags_t r;
    r = '0;
    r[pos] = 1'b1;
    return r;
  endfunction

  // Keep a single flag by priority when more than one is set
  function automatic xflags_t pick_one(xflags_t e);
    xflags_t r;
    r = e;
    if ((e & (e - xflags_t'(1))) != '0) begin
      if (e[XV_INV])     r = one_hot_at(XV_INV);
      else if (e[XV_DZ]) r = one_hot_at(XV_DZ);
      else if (e[XV_NX]) r = one_hot_at(XV_NX);
    end
    return r;
  endfunction

  // Untrapped overflow/underflow also report inexact
  function automatic xflags_t widen_cur(xflags_t f);
    xflags_t r;
    r = f;
    if (f[XV_OVF] | f[XV_UNF]) r[XV_NX] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/fpx_trap_sel.sv
module fpx_trap_sel
  import fpx_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W-1:0] mask,
  output logic              trap,
  output logic [FLAG_W-1:0] rep
);
  logic [FLAG_W-1:0] masked;

  assign masked = flags & mask;
  assign trap   = |masked;
  assign rep    = trap ? pick_one(masked) : widen_cur(flags);
endmodule

// File: rtl/fpx_field_merge.sv
module fpx_field_merge
  import fpx_pkg::*;
(
  input  logic [STAT_W-1:0] cur,
  input  logic              trap,
  input  logic [FLAG_W-1:0] rep,
  input  logic [FLAG_W-1:0] raw,
  output logic [STAT_W-1:0] nxt
);
  logic [FLAG_W-1:0] acc_cur;

  assign acc_cur = cur[ACC_LSB +: FLAG_W];

  always_comb begin
    nxt = cur;
    nxt[CUR_LSB +: FLAG_W] = rep;
    if (trap) begin
      nxt[ACC_LSB +: FLAG_W] = '0;
      nxt[TTYPE_BIT]         = 1'b1;
    end else begin
      nxt[ACC_LSB +: FLAG_W] = acc_cur | raw;
    end
  end
endmodule

// File: rtl/fpx_status_rec.sv
module fpx_status_rec
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              flag_vld,
  input  logic [FLAG_W-1:0] flag_vec,
  output logic [STAT_W-1:0] status_q,
  output logic              ok_q
);
  logic [FLAG_W-1:0] mask_w;
  logic              trap_w;
  logic [FLAG_W-1:0] rep_w;
  logic [STAT_W-1:0] nxt_w;
  logic              ev_w;
  logic              trap_ev_w;

  assign mask_w    = status_q[MASK_LSB +: FLAG_W];
  assign ev_w      = flag_vld & ~wr_en;
  assign trap_ev_w = ev_w & |(flag_vec & mask_w);

  fpx_trap_sel u_sel (
    .flags (flag_vec),
    .mask  (mask_w),
    .trap  (trap_w),
    .rep   (rep_w)
  );

  fpx_field_merge u_merge (
    .cur  (status_q),
    .trap (trap_w),
    .rep  (rep_w),
    .raw  (flag_vec),
    .nxt  (nxt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      ok_q     <= 1'b1;
    end else if (wr_en) begin
      status_q <= wr_data;
    end else if (flag_vld) begin
      if (|flag_vec) status_q <= nxt_w;
      ok_q <= ~trap_w;
    end
  end

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status_q == $past(wr_data));

  // R3
  trap_ok_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ev_w |=> !ok_q);

  // R4
  trap_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ev_w |=> (status_q[CUR_LSB +: FLAG_W] & ~$past(mask_w)) == '0);

  // R6
  untrap_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_w && !trap_ev_w && (flag_vec[XV_OVF] || flag_vec[XV_UNF]))
      |=> status_q[CUR_LSB + XV_NX] && ok_q);

  // R7
  trap_acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ev_w |=> status_q[ACC_LSB +: FLAG_W] == '0);

  // R8
  trap_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ev_w |=> status_q[TTYPE_BIT]);

  // R9
  zero_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_w && flag_vec == '0) |=> $stable(status_q) && ok_q);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !flag_vld) |=> $stable(status_q) && $stable(ok_q));
endmodule

// File: tb/tb_fpx_status_rec.sv
module tb_fpx_status_rec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        flag_vld = 1'b0;
  logic [4:0]  flag_vec = '0;
  logic [31:0] status_q;
  logic        ok_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fpx_status_rec dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .flag_vld(flag_vld), .flag_vec(flag_vec),
    .status_q(status_q), .ok_q(ok_q)
  );

  // {initial status, flags, expected status, expected ok}
  localparam logic [69:0] VECS [13] = '{
    {32'h00000000, 5'b00001, 32'h00000021, 1'b1},
    {32'h0000003F, 5'b01000, 32'h00000129, 1'b1},
    {32'h00000000, 5'b00100, 32'h00000085, 1'b1},
    {32'h08000060, 5'b10001, 32'h08004010, 1'b0},
    {32'h0F800000, 5'b10011, 32'h0F804010, 1'b0},
    {32'h01800000, 5'b00011, 32'h01804002, 1'b0},
    {32'h06800000, 5'b01001, 32'h06804001, 1'b0},
    {32'h06000000, 5'b01100, 32'h0600400C, 1'b0},
    {32'h08000200, 5'b01000, 32'h08000309, 1'b1},
    {32'h040003E0, 5'b01000, 32'h04004008, 1'b0},
    {32'h8F8013E5, 5'b00000, 32'h8F8013E5, 1'b1},
    {32'hF0803000, 5'b00001, 32'hF0807001, 1'b0},
    {32'h00004000, 5'b00010, 32'h00004042, 1'b1}
  };

  task automatic check(input bit cond, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire(input logic [4:0] f);
    flag_vld = 1'b1; flag_vec = f;
    @(negedge clk);
    flag_vld = 1'b0; flag_vec = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(status_q == 32'h0, "R1 status", status_q, 32'h0);
    check(ok_q == 1'b1, "R1 ok", {31'b0, ok_q}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(status_q == 32'h0 && ok_q, "R1 after release", status_q, 32'h0);

    // Table: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 13; i++) begin
      load(VECS[i][69:38]);
      fire(VECS[i][37:33]);
      check(status_q == VECS[i][32:1],
            $sformatf("R4 R5 R6 R7 R8 R9 entry %0d status", i),
            status_q, VECS[i][32:1]);
      check(ok_q == VECS[i][0], $sformatf("R3 entry %0d ok", i),
            {31'b0, ok_q}, {31'b0, VECS[i][0]});
    end

    // R10: after a trap, idle cycles hold both outputs
    load(32'h00800000);
    fire(5'b00001);
    repeat (4) @(negedge clk);
    check(status_q == 32'h00804001, "R10 status hold", status_q, 32'h00804001);
    check(ok_q == 1'b0, "R10 ok hold", {31'b0, ok_q}, 32'h0);

    // R2: write wins over a simultaneous event; ok_q unchanged
    wr_en = 1'b1; wr_data = 32'h00800000;
    flag_vld = 1'b1; flag_vec = 5'b00100;
    @(negedge clk);
    wr_en = 1'b0; flag_vld = 1'b0; flag_vec = '0;
    check(status_q == 32'h00800000, "R2 write priority", status_q, 32'h00800000);
    check(ok_q == 1'b0, "R2 ok kept", {31'b0, ok_q}, 32'h0);

    // R9: zero flags restores ok and keeps status
    fire(5'b00000);
    check(status_q == 32'h00800000, "R9 zero status", status_q, 32'h00800000);
    check(ok_q == 1'b1, "R9 zero ok", {31'b0, ok_q}, 32'h1);

    // R7: accrued accumulates over back-to-back untrapped events
    fire(5'b00100);
    fire(5'b00010);
    check(status_q == 32'h008000C2, "R7 accumulate", status_q, 32'h008000C2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule